// File: doc/BRIEF.md
# PWM Fault Override Controller

This block sits between a four-pair complementary PWM generator and the output pins. It takes two active-low fault inputs. The primary input outranks the secondary one. Each input has its own 16-bit configuration register on a simple register bus. When a fault input is asserted, every pair that its configuration enables is forced to that register's programmed override levels. Pairs it does not enable pass the generator's waveforms through unchanged.

Each fault source works in one of two modes:

- **Latched mode:** the override stays in force until software writes one to the source's bit in the status register. A clear written while the fault is still asserted has no effect.
- **Cycle-by-cycle mode:** the override is released by the first PWM period-start pulse that arrives while the fault is deasserted.

Both fault inputs pass through a two-stage synchroniser. A per-pin polarity input is applied after the override multiplexer, so an override bit of 1 always means the pin's active level.

Top module: `pwm_fault_override`

## Requirements
- R1: After reset, all three registers read 0. Each pin equals its PWM input XOR its polarity input.
- R2: Register layout, at address 0 (primary) and address 1 (secondary):
  - bits 15..8 are the override levels. Pair p (p = 1..4) has its high pin at bit 7+2p and its low pin at bit 6+2p.
  - bit 7 selects the mode: 1 for cycle-by-cycle, 0 for latched.
  - bits 3..0 are the enables for pairs 4..1.
  - bits 6..4 always read 0, so writing 16'hFFFF reads back 16'hFF8F.
- R3: A fault input driven low engages its override on the third rising clock edge after the change, and not before. While engaged, each enabled pair is driven to its override bits: 1 means active, 0 means inactive.
- R4: In latched mode, an engaged override holds after the fault input returns high. It is released at the clock edge of a write to address 2 with the source's bit set (bit 0 primary, bit 1 secondary). The same write has no effect while the synchronised fault is still asserted.
- R5: In cycle-by-cycle mode, a period-start pulse does not release the override while the synchronised fault is asserted. The override is released at the first period-start pulse after the synchronised fault has deasserted.
- R6: A pair whose enable bit is 0 in both engaged sources follows its PWM inputs while the other pairs are overridden.
- R7: When both sources are engaged, a pair enabled in the primary register takes the primary override levels. A pair enabled only in the secondary register takes the secondary levels.
- R8: The polarity inputs are applied after the override selection: each pin equals its selected level XOR its polarity bit.
- R9: Address 2 reads the engaged state of the primary source in bit 0 and of the secondary source in bit 1, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 primary, 1 secondary, 2 status) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| fault_pri_n | input | 1 | Primary fault input, active low, asynchronous |
| fault_sec_n | input | 1 | Secondary fault input, active low, asynchronous |
| period_start | input | 1 | One-cycle pulse at each PWM period start |
| pwm_hi | input | 4 | High-side PWM levels, bit p-1 is pair p |
| pwm_lo | input | 4 | Low-side PWM levels |
| pol_hi | input | 4 | High-side polarity, 1 inverts the pin |
| pol_lo | input | 4 | Low-side polarity |
| pin_hi | output | 4 | High-side pin levels |
| pin_lo | output | 4 | Low-side pin levels |

## Verification
The override path is tried under several stimulus patterns:

- **Secondary source alone, latched.** Override bits differ between pairs and two pairs are left disabled. This separates enabled pairs from pass-through pairs, and an override of 1 from an override of 0.
- **Primary source alone, cycle-by-cycle.** Period-start pulses arrive both during and after the fault. This tells holding from release.
- **Both sources at once with overlapping enables.** The two sources carry opposite override values, so only correct priority gives the expected pins.
- **Inverted polarity on the priority pattern.** This shows that inversion follows the selection.

Clears written while a fault is still present, together with the two- and three-edge latency samples, separate the synchroniser timing and the write-one-to-clear guard.

// File: rtl/pfo_pkg.sv
package pfo_pkg;
    localparam int N_PAIRS  = 4;
    localparam int REG_W    = 16;
    localparam int OVR_LSB  = 8;
    localparam int MODE_BIT = 7;
    localparam int ADDR_W   = 2;
    localparam int N_SRC    = 2;

    localparam logic [ADDR_W-1:0] ADDR_PRI  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_SEC  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    typedef struct packed {
        logic [N_PAIRS-1:0] ovr_hi;
        logic [N_PAIRS-1:0] ovr_lo;
        logic               cbc;
        logic [N_PAIRS-1:0] en;
    } fault_cfg_t;

    function automatic logic [REG_W-1:0] impl_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i >= OVR_LSB || i == MODE_BIT || i < N_PAIRS) m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [REG_W-1:0] IMPL_MASK = impl_mask();

    function automatic fault_cfg_t decode_cfg(input logic [REG_W-1:0] r);
        fault_cfg_t c;
        for (int p = 0; p < N_PAIRS; p++) begin
            c.ovr_hi[p] = r[OVR_LSB + 2*p + 1];
            c.ovr_lo[p] = r[OVR_LSB + 2*p];
        end
        c.cbc = r[MODE_BIT];
        c.en  = r[N_PAIRS-1:0];
        return c;
    endfunction
endpackage

// File: rtl/pfo_sync.sv
module pfo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_n,
    output logic active
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], ~fault_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.chain[STAGES-1];
endmodule

// File: rtl/pfo_engage.sv
module pfo_engage (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic cbc,
    input  logic period_start,
    input  logic clr,
    output logic engaged
);
    typedef struct packed {
        logic engaged;
    } eng_t;

    eng_t st_d, st_q;
    logic release_ev;

    always_comb begin
        release_ev = cbc ? period_start : clr;
        st_d = st_q;
        st_d.engaged = active | (st_q.engaged & ~release_ev);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign engaged = st_q.engaged;
endmodule

// File: rtl/pfo_regs.sv
module pfo_regs
    import pfo_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    input  logic [N_SRC-1:0]        engaged,
    output fault_cfg_t              cfg_pri,
    output fault_cfg_t              cfg_sec,
    output logic [N_SRC-1:0]        clr
);
    typedef struct packed {
        logic [REG_W-1:0] pri;
        logic [REG_W-1:0] sec;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_PRI:  st_d.pri = reg_wdata & IMPL_MASK;
                ADDR_SEC:  st_d.sec = reg_wdata & IMPL_MASK;
                ADDR_STAT: clr      = reg_wdata[N_SRC-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_PRI:  reg_rdata = st_q.pri;
            ADDR_SEC:  reg_rdata = st_q.sec;
            ADDR_STAT: reg_rdata = {{(REG_W-N_SRC){1'b0}}, engaged};
            default:   reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_pri = decode_cfg(st_q.pri);
    assign cfg_sec = decode_cfg(st_q.sec);
endmodule

// File: rtl/pfo_outmux.sv
module pfo_outmux
    import pfo_pkg::*;
(
    input  fault_cfg_t          cfg_pri,
    input  fault_cfg_t          cfg_sec,
    input  logic [N_SRC-1:0]    engaged,
    input  logic [N_PAIRS-1:0]  pwm_hi,
    input  logic [N_PAIRS-1:0]  pwm_lo,
    input  logic [N_PAIRS-1:0]  pol_hi,
    input  logic [N_PAIRS-1:0]  pol_lo,
    output logic [N_PAIRS-1:0]  pin_hi,
    output logic [N_PAIRS-1:0]  pin_lo
);
    for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
        logic sel_pri, sel_sec, lvl_hi, lvl_lo;
        always_comb begin
            sel_pri = engaged[0] & cfg_pri.en[p];
            sel_sec = engaged[1] & cfg_sec.en[p];
            if (sel_pri) begin
                lvl_hi = cfg_pri.ovr_hi[p];
                lvl_lo = cfg_pri.ovr_lo[p];
            end else if (sel_sec) begin
                lvl_hi = cfg_sec.ovr_hi[p];
                lvl_lo = cfg_sec.ovr_lo[p];
            end else begin
                lvl_hi = pwm_hi[p];
                lvl_lo = pwm_lo[p];
            end
        end
        assign pin_hi[p] = lvl_hi ^ pol_hi[p];
        assign pin_lo[p] = lvl_lo ^ pol_lo[p];
    end
endmodule

// File: rtl/pwm_fault_override.sv
module pwm_fault_override
    import pfo_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [15:0]         reg_wdata,
    output logic [15:0]         reg_rdata,
    input  logic                fault_pri_n,
    input  logic                fault_sec_n,
    input  logic                period_start,
    input  logic [3:0]          pwm_hi,
    input  logic [3:0]          pwm_lo,
    input  logic [3:0]          pol_hi,
    input  logic [3:0]          pol_lo,
    output logic [3:0]          pin_hi,
    output logic [3:0]          pin_lo
);
    fault_cfg_t         cfg_pri, cfg_sec;
    logic [N_SRC-1:0]   fault_n_vec, fault_act, engaged, clr, cbc_vec;

    assign fault_n_vec = {fault_sec_n, fault_pri_n};
    assign cbc_vec     = {cfg_sec.cbc, cfg_pri.cbc};

    pfo_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .engaged   (engaged),
        .cfg_pri   (cfg_pri),
        .cfg_sec   (cfg_sec),
        .clr       (clr)
    );

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        pfo_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .fault_n (fault_n_vec[s]),
            .active  (fault_act[s])
        );
        pfo_engage u_eng (
            .clk          (clk),
            .rst_n        (rst_n),
            .active       (fault_act[s]),
            .cbc          (cbc_vec[s]),
            .period_start (period_start),
            .clr          (clr[s]),
            .engaged      (engaged[s])
        );
    end

    pfo_outmux u_mux (
        .cfg_pri (cfg_pri),
        .cfg_sec (cfg_sec),
        .engaged (engaged),
        .pwm_hi  (pwm_hi),
        .pwm_lo  (pwm_lo),
        .pol_hi  (pol_hi),
        .pol_lo  (pol_lo),
        .pin_hi  (pin_hi),
        .pin_lo  (pin_lo)
    );
endmodule

// File: rtl/pfo_checker.sv
module pfo_checker
    import pfo_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         reg_wr,
    input logic [1:0]   reg_addr,
    input logic [15:0]  reg_wdata,
    input logic [15:0]  reg_rdata,
    input logic         period_start,
    input logic [3:0]   pwm_hi,
    input logic [3:0]   pwm_lo,
    input logic [3:0]   pol_hi,
    input logic [3:0]   pol_lo,
    input logic [3:0]   pin_hi,
    input logic [3:0]   pin_lo,
    input logic [1:0]   engaged,
    input fault_cfg_t   cfg_pri,
    input fault_cfg_t   cfg_sec
);
    logic pri_clr_wr;
    assign pri_clr_wr = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[0];

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != ADDR_STAT) |-> (reg_rdata[6:4] == 3'b000)); // R2

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (engaged[0] && !cfg_pri.cbc && !pri_clr_wr) |=> engaged[0]); // R4

    AST_CBC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (engaged[0] && cfg_pri.cbc && !period_start) |=> engaged[0]); // R5

    for (genvar p = 0; p < N_PAIRS; p++) begin : g_chk
        AST_PRI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (engaged[0] && cfg_pri.en[p]) |->
            (pin_hi[p] == (cfg_pri.ovr_hi[p] ^ pol_hi[p]) &&
             pin_lo[p] == (cfg_pri.ovr_lo[p] ^ pol_lo[p]))); // R7

        AST_UNCTRL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            (!(engaged[0] && cfg_pri.en[p]) && !(engaged[1] && cfg_sec.en[p])) |->
            (pin_hi[p] == (pwm_hi[p] ^ pol_hi[p]) &&
             pin_lo[p] == (pwm_lo[p] ^ pol_lo[p]))); // R6
    end
endmodule

bind pwm_fault_override pfo_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .period_start (period_start),
    .pwm_hi       (pwm_hi),
    .pwm_lo       (pwm_lo),
    .pol_hi       (pol_hi),
    .pol_lo       (pol_lo),
    .pin_hi       (pin_hi),
    .pin_lo       (pin_lo),
    .engaged      (engaged),
    .cfg_pri      (cfg_pri),
    .cfg_sec      (cfg_sec)
);

// File: tb/tb_pwm_fault_override.sv
`timescale 1ns/1ps
module tb_pwm_fault_override;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        fault_pri_n = 1'b1;
    logic        fault_sec_n = 1'b1;
    logic        period_start = 1'b0;
    logic [3:0]  pwm_hi = 4'd0, pwm_lo = 4'd0, pol_hi = 4'd0, pol_lo = 4'd0;
    logic [3:0]  pin_hi, pin_lo;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwm_fault_override dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fault_pri_n(fault_pri_n), .fault_sec_n(fault_sec_n),
        .period_start(period_start), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .pol_hi(pol_hi), .pol_lo(pol_lo), .pin_hi(pin_hi), .pin_lo(pin_lo)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_period();
        period_start = 1'b1;
        step(1);
        period_start = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        pwm_hi = 4'b1010; pwm_lo = 4'b0101; pol_hi = 4'b0011; pol_lo = 4'b0000;
        #1;
        reg_read(2'd0, v); check("R1 pri reg", v, 16'h0000);
        reg_read(2'd1, v); check("R1 sec reg", v, 16'h0000);
        reg_read(2'd2, v); check("R1 status", v, 16'h0000);
        check("R1 pin_hi", {12'd0, pin_hi}, {12'd0, 4'b1001});
        check("R8 pin_lo no inversion", {12'd0, pin_lo}, {12'd0, 4'b0101});
        pol_hi = 4'b0000;
    endtask

    task automatic t_regs();
        logic [15:0] v;
        reg_write(2'd1, 16'hFFFF);
        reg_read(2'd1, v); check("R2 reserved bits read 0", v, 16'hFF8F);
        reg_write(2'd1, 16'h0000);
        reg_read(2'd1, v); check("R2 cleared", v, 16'h0000);
    endtask

    task automatic t_latched();
        logic [15:0] v;
        pwm_hi = 4'b0000; pwm_lo = 4'b1111;
        reg_write(2'd1, 16'h0603);
        fault_sec_n = 1'b0;
        step(2);
        check("R3 not yet after two edges", {12'd0, pin_hi}, 16'h0000);
        step(1);
        check("R3 pin_hi overridden", {12'd0, pin_hi}, 16'h0001);
        check("R6 pin_lo pairs 3,4 pass", {12'd0, pin_lo}, 16'h000E);
        reg_read(2'd2, v); check("R9 status secondary", v, 16'h0002);
        reg_write(2'd2, 16'h0002);
        check("R4 clear ignored during fault", {12'd0, pin_hi}, 16'h0001);
        fault_sec_n = 1'b1;
        step(4);
        reg_read(2'd2, v); check("R4 holds after fault gone", v, 16'h0002);
        reg_write(2'd2, 16'h0002);
        check("R4 released by clear hi", {12'd0, pin_hi}, 16'h0000);
        check("R4 released by clear lo", {12'd0, pin_lo}, 16'h000F);
        reg_read(2'd2, v); check("R9 status cleared", v, 16'h0000);
        reg_write(2'd1, 16'h0000);
    endtask

    task automatic t_cbc();
        logic [15:0] v;
        pwm_hi = 4'b0000; pwm_lo = 4'b0000;
        reg_write(2'd0, 16'h3084);
        fault_pri_n = 1'b0;
        step(3);
        check("R5 cbc engaged", {12'd0, pin_hi}, 16'h0004);
        pulse_period();
        check("R5 held during fault", {12'd0, pin_lo}, 16'h0004);
        fault_pri_n = 1'b1;
        step(3);
        check("R5 held until boundary", {12'd0, pin_hi}, 16'h0004);
        pulse_period();
        check("R5 released at boundary", {12'd0, pin_hi}, 16'h0000);
        reg_read(2'd2, v); check("R9 status after release", v, 16'h0000);
        reg_write(2'd0, 16'h0000);
    endtask

    task automatic t_priority();
        pwm_hi = 4'b0000; pwm_lo = 4'b0000; pol_hi = 4'b0000; pol_lo = 4'b0000;
        reg_write(2'd0, 16'h0303);
        reg_write(2'd1, 16'h2C07);
        fault_pri_n = 1'b0; fault_sec_n = 1'b0;
        step(3);
        check("R7 priority pin_hi", {12'd0, pin_hi}, 16'h0005);
        check("R7 priority pin_lo", {12'd0, pin_lo}, 16'h0001);
        pol_hi = 4'b1111;
        #1;
        check("R8 polarity after mux", {12'd0, pin_hi}, 16'h000A);
        pol_hi = 4'b0000;
        fault_pri_n = 1'b1; fault_sec_n = 1'b1;
        step(3);
        reg_write(2'd2, 16'h0003);
        reg_write(2'd0, 16'h0000);
        reg_write(2'd1, 16'h0000);
        check("R7 all released", {12'd0, pin_hi}, 16'h0000);
    endtask

    initial begin
        #4_000_000;
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_regs();
        t_latched();
        t_cbc();
        t_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule